// File: doc/BRIEF.md
# Interrupt Message Routing Engine

This block sits between a bank of interrupt input pins and a message fabric that carries interrupts to processors. When an input pin goes from low to high, the block reads that pin's routing entry, a packed word held outside the block. If the entry is blocked, the request is dropped. Otherwise the block builds one interrupt message. The message carries a vector, a copy of the entry's attribute bits and a one-hot-per-processor target mask.

The vector normally comes from the entry. In external mode it comes from a legacy controller's vector input. Targets are found in one of two ways. In direct addressing, a destination byte names one processor by number, or all processors when the byte is 0xFF. In group addressing, each processor's group byte is ANDed with the destination byte. For the "any one of the group" delivery type, the matched group is cut down to a single processor by a rotating counter. This spreads successive requests across the group. It is not a true priority arbitration.

Several pins may rise together. Their edges are kept pending and served one per cycle, lowest pin number first. The output register holds one message under a valid/ready handshake.

Top module: `ioredir_route`

## Requirements
- R1: Only a low-to-high change on a pin creates a request. A pin held high gives no further requests until it has gone low and risen again. Out of reset, `msg_valid_o` and `err_o` are 0. When the output is free, the message is valid in the cycle after the edge in which the pin is first seen high.
- R2: When entry bit 14 (block) is 1, the request is dropped, no message appears and `err_o` stays 0.
- R3: When entry bits [10:8] (delivery type) equal 3'b111 (external), the message vector is `ext_vec_i`, sampled when the message is loaded. For every other delivery type the vector is entry bits [7:0].
- R4: The message copies these fields from the entry unchanged: destination (bits [23:16]), delivery type (bits [10:8]), addressing mode (bit 11, where 1 means group), level (bit 12) and trigger (bit 13).
- R5: In direct addressing (bit 11 = 0), destination 0xFF targets all processors. Any other value targets only processor d, where d is the destination. If d is not below NUM_CPU, the target mask is all zero.
- R6: In group addressing, processor i is targeted when `log_ids_i[8i+7:8i]` AND the destination is nonzero.
- R7: For delivery type 3'b001 (any-one) in group addressing with a non-empty matched set, the target is the matched processor at position k (counting from 0 in ascending processor order). Here k is a rotating counter modulo the set size. The counter starts at 0 after reset and increments after each such selection.
- R8: A delivery type 3'b001 request in direct addressing is dropped, and `err_o` is 1 for exactly one cycle.
- R9: Edges that rise in the same cycle stay pending and are served one per cycle, lowest pin number first. No edge is lost.
- R10: While `msg_valid_o` is 1 and `msg_ready_i` is 0, the message and its target mask do not change.
- R11: A delivery type 3'b001 request in group addressing with an empty matched set gives a message with an all-zero target mask. It does not advance the rotating counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pins_i | input | NUM_PINS | Interrupt input pins |
| entries_i | input | NUM_PINS*24 | Routing entries, 24 bits per pin |
| ext_vec_i | input | 8 | Vector from the external legacy controller |
| log_ids_i | input | NUM_CPU*8 | Group byte of each processor |
| msg_ready_i | input | 1 | Fabric accepts the message |
| msg_valid_o | output | 1 | Message valid |
| msg_vector_o | output | 8 | Message vector |
| msg_dest_o | output | 8 | Destination byte |
| msg_dmode_o | output | 3 | Delivery type |
| msg_dlog_o | output | 1 | Addressing mode, 1 = group |
| msg_level_o | output | 1 | Level bit (from polarity) |
| msg_trig_o | output | 1 | Trigger mode |
| msg_targets_o | output | NUM_CPU | One-hot-per-processor target mask |
| err_o | output | 1 | Pulse: unsupported direct any-one request dropped |

## Verification
Two things can land in the same cycle: a second pin edge arriving while the output is stalled, and the release of that stalled message. The bench raises two pins together with ready held low. It checks that the first message stays frozen while the second edge waits. It then pulses ready once and expects the second pin's message in the very next cycle, with no gap and no loss. The rotating any-one selection is also checked against an empty-group request placed between two selections, to show that the counter does not move for the empty case.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;
   localparam int ENT_W  = 24;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic [7:0] dest;
      logic       rsvd;
      logic       block;
      logic       trig;
      logic       pol;
      logic       dlog;
      logic [2:0] dmode;
      logic [7:0] vector;
   } route_ent_t;

   localparam logic [2:0] DM_FIXED  = 3'b000;
   localparam logic [2:0] DM_ANYONE = 3'b001;
   localparam logic [2:0] DM_EXT    = 3'b111;
endpackage

// File: rtl/ioredir_edge_queue.sv
module ioredir_edge_queue #(
   parameter int N  = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  pins_i,
   input  logic          take_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   logic [N-1:0] pin_q, pend_q, req, grant;

   assign req   = pend_q | (pins_i & ~pin_q);
   assign any_o = |req;

   // lowest index wins: scan downward, last hit overrides
   always_comb begin
      idx_o = '0;
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx_o    = IW'(i);
            grant    = '0;
            grant[i] = take_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q  <= '0;
         pend_q <= '0;
      end else begin
         pin_q  <= pins_i;
         pend_q <= req & ~grant;
      end
   end
endmodule

// File: rtl/ioredir_dest_match.sv
module ioredir_dest_match #(
   parameter int NUM_CPU = 8
) (
   input  logic [7:0]           dest_i,
   input  logic                 dlog_i,
   input  logic [NUM_CPU*8-1:0] log_ids_i,
   output logic [NUM_CPU-1:0]   match_o
);
   for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
      localparam logic [7:0] CPU_ID = 8'(g);
      logic grp_hit, dir_hit;
      assign grp_hit    = |(log_ids_i[g*8 +: 8] & dest_i);
      assign dir_hit    = (dest_i == 8'hFF) || (dest_i == CPU_ID);
      assign match_o[g] = dlog_i ? grp_hit : dir_hit;
   end
endmodule

// File: rtl/ioredir_lowpri_pick.sv
module ioredir_lowpri_pick #(
   parameter int NUM_CPU = 8,
   parameter int CNT_W   = 16,
   localparam int CW     = $clog2(NUM_CPU + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CPU-1:0] match_i,
   input  logic               advance_i,
   output logic [NUM_CPU-1:0] pick_o
);
   logic [CNT_W-1:0] rot_q, rem, seen;
   logic [CW-1:0]    cnt;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NUM_CPU; i++) cnt = cnt + CW'(match_i[i]);
   end

   assign rem = (cnt == '0) ? '0 : rot_q % CNT_W'(cnt);

   always_comb begin
      pick_o = '0;
      seen   = '0;
      for (int i = 0; i < NUM_CPU; i++) begin
         if (match_i[i]) begin
            if (seen == rem) pick_o[i] = 1'b1;
            seen = seen + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rot_q <= '0;
      else if (advance_i) rot_q <= rot_q + 1'b1;
   end
endmodule

// File: rtl/ioredir_route.sv
module ioredir_route
   import ioredir_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int NUM_CPU  = 8,
   parameter int CNT_W    = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pins_i,
   input  logic [NUM_PINS*24-1:0] entries_i,
   input  logic [7:0]            ext_vec_i,
   input  logic [NUM_CPU*8-1:0]  log_ids_i,
   input  logic                  msg_ready_i,
   output logic                  msg_valid_o,
   output logic [7:0]            msg_vector_o,
   output logic [7:0]            msg_dest_o,
   output logic [2:0]            msg_dmode_o,
   output logic                  msg_dlog_o,
   output logic                  msg_level_o,
   output logic                  msg_trig_o,
   output logic [NUM_CPU-1:0]    msg_targets_o,
   output logic                  err_o
);
   localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   if (NUM_CPU < 1 || NUM_CPU > 255) begin : g_bad_cpu
      $error("NUM_CPU must be 1..255 (0xFF is the broadcast id)");
   end
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("NUM_PINS must be at least 1");
   end
   if (CNT_W < $clog2(NUM_CPU + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for the group size");
   end

   route_ent_t ent_arr [NUM_PINS];
   for (genvar g = 0; g < NUM_PINS; g++) begin : g_unpack
      assign ent_arr[g] = route_ent_t'(entries_i[g*ENT_W +: ENT_W]);
   end

   logic          any, take, free, issue, drop_err, anyone, grp_anyone, advance;
   logic [IW-1:0] idx;
   route_ent_t    ent;
   logic [NUM_CPU-1:0] match, pick, targets_n;

   assign free = !msg_valid_o || msg_ready_i;
   assign take = free && any;

   ioredir_edge_queue #(.N(NUM_PINS)) u_edges (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
      .take_i(take), .any_o(any), .idx_o(idx)
   );

   assign ent        = ent_arr[idx];
   assign anyone     = (ent.dmode == DM_ANYONE);
   assign grp_anyone = anyone && ent.dlog;
   assign issue      = take && !ent.block && !(anyone && !ent.dlog);
   assign drop_err   = take && !ent.block && anyone && !ent.dlog;
   assign advance    = issue && grp_anyone && (|match);

   ioredir_dest_match #(.NUM_CPU(NUM_CPU)) u_match (
      .dest_i(ent.dest), .dlog_i(ent.dlog),
      .log_ids_i(log_ids_i), .match_o(match)
   );

   ioredir_lowpri_pick #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .match_i(match),
      .advance_i(advance), .pick_o(pick)
   );

   assign targets_n = grp_anyone ? pick : match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid_o   <= 1'b0;
         msg_vector_o  <= '0;
         msg_dest_o    <= '0;
         msg_dmode_o   <= '0;
         msg_dlog_o    <= 1'b0;
         msg_level_o   <= 1'b0;
         msg_trig_o    <= 1'b0;
         msg_targets_o <= '0;
         err_o         <= 1'b0;
      end else begin
         err_o <= drop_err;
         if (free) msg_valid_o <= issue;
         if (issue) begin
            msg_vector_o  <= (ent.dmode == DM_EXT) ? ext_vec_i : ent.vector;
            msg_dest_o    <= ent.dest;
            msg_dmode_o   <= ent.dmode;
            msg_dlog_o    <= ent.dlog;
            msg_level_o   <= ent.pol;
            msg_trig_o    <= ent.trig;
            msg_targets_o <= targets_n;
         end
      end
   end
endmodule

// File: rtl/ioredir_chk.sv
module ioredir_chk #(
   parameter int NUM_CPU = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msg_ready_i,
   input logic               msg_valid_o,
   input logic [7:0]         msg_vector_o,
   input logic [7:0]         msg_dest_o,
   input logic [2:0]         msg_dmode_o,
   input logic               msg_dlog_o,
   input logic [NUM_CPU-1:0] msg_targets_o,
   input logic               err_o
);
   AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_targets_o)
         && $stable(msg_vector_o) && $stable(msg_dest_o)); // R10
   AST_DIRECT_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o && !msg_dlog_o && msg_dest_o == 8'hFF |-> &msg_targets_o); // R5
   AST_DIRECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o && !msg_dlog_o && msg_dest_o != 8'hFF |-> $onehot0(msg_targets_o)); // R5
   AST_ANYONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o && msg_dmode_o == 3'b001 |-> $onehot0(msg_targets_o)); // R7
   AST_NO_DIRECT_ANYONE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid_o |-> !(msg_dmode_o == 3'b001 && !msg_dlog_o)); // R8
   AST_ERR_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !msg_valid_o); // R8
endmodule

bind ioredir_route ioredir_chk #(.NUM_CPU(NUM_CPU)) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_ready_i(msg_ready_i),
   .msg_valid_o(msg_valid_o), .msg_vector_o(msg_vector_o),
   .msg_dest_o(msg_dest_o), .msg_dmode_o(msg_dmode_o),
   .msg_dlog_o(msg_dlog_o), .msg_targets_o(msg_targets_o), .err_o(err_o)
);

// File: tb/ioredir_route_tb.sv
`timescale 1ns/1ps
module ioredir_route_tb;
   localparam int NP = 8;
   localparam int NC = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    pins = '0;
   logic [NP*24-1:0] ents = '0;
   logic [7:0]       ext_vec = 8'h00;
   logic [NC*8-1:0]  log_ids = '0;
   logic             ready = 1'b0;
   logic             valid, dlog, level, trig, err;
   logic [7:0]       vector, dest;
   logic [2:0]       dmode;
   logic [NC-1:0]    targets;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ioredir_route #(.NUM_PINS(NP), .NUM_CPU(NC)) u_dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .entries_i(ents),
      .ext_vec_i(ext_vec), .log_ids_i(log_ids), .msg_ready_i(ready),
      .msg_valid_o(valid), .msg_vector_o(vector), .msg_dest_o(dest),
      .msg_dmode_o(dmode), .msg_dlog_o(dlog), .msg_level_o(level),
      .msg_trig_o(trig), .msg_targets_o(targets), .err_o(err)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic set_ent(int p, logic [7:0] vec, logic [2:0] dm, logic dl,
                          logic pol, logic tr, logic blk, logic [7:0] dst);
      ents[p*24 +: 24] = {dst, 1'b0, blk, tr, pol, dl, dm, vec};
   endtask

   task automatic cyc(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic raise(int p);
      pins[p] = 1'b1;
      cyc();
   endtask

   task automatic lower(int p);
      pins[p] = 1'b0;
      cyc();
   endtask

   task automatic consume();
      ready = 1'b1;
      cyc();
      ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset valid", 32'(valid), 0);
      chk("R1 reset err", 32'(err), 0);
   endtask

   task automatic t_direct_fixed();
      set_ent(0, 8'h41, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3);
      raise(0);
      chk("R1 latency valid", 32'(valid), 1);
      chk("R5 direct target", 32'(targets), 32'h08);
      chk("R4 fields", {vector, dest, 5'(dmode), dlog, level, trig},
          {8'h41, 8'd3, 5'd0, 1'b0, 1'b1, 1'b1});
      cyc(2);
      chk("R10 held valid", 32'(valid), 1);
      chk("R10 held targets", 32'(targets), 32'h08);
      consume();
      chk("R10 released", 32'(valid), 0);
      lower(0);
   endtask

   task automatic t_held_pin();
      set_ent(1, 8'h52, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0);
      raise(1);
      chk("R1 first edge", 32'(vector), 32'h52);
      consume();
      cyc(3);
      chk("R1 held high no repeat", 32'(valid), 0);
      lower(1);
      raise(1);
      chk("R1 re-armed valid", 32'(valid), 1);
      chk("R5 cpu0 target", 32'(targets), 32'h01);
      consume();
      lower(1);
   endtask

   task automatic t_blocked();
      set_ent(2, 8'h63, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1);
      raise(2);
      chk("R2 blocked no msg", 32'(valid), 0);
      chk("R2 blocked no err", 32'(err), 0);
      cyc(2);
      chk("R2 still no msg", 32'(valid), 0);
      lower(2);
   endtask

   task automatic t_bcast();
      set_ent(3, 8'h70, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
      raise(3);
      chk("R5 broadcast", 32'(targets), 32'hFF);
      consume();
      lower(3);
      set_ent(3, 8'h71, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9);
      raise(3);
      chk("R5 out-of-range valid", 32'(valid), 1);
      chk("R5 out-of-range targets", 32'(targets), 0);
      consume();
      lower(3);
   endtask

   task automatic t_ext();
      set_ent(4, 8'h11, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2);
      ext_vec = 8'hC5;
      raise(4);
      chk("R3 external vector", 32'(vector), 32'hC5);
      chk("R4 external dmode", 32'(dmode), 32'h7);
      consume();
      lower(4);
   endtask

   task automatic t_group();
      set_ent(5, 8'h5A, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h05);
      raise(5);
      chk("R6 group match", 32'(targets), 32'h0D);
      chk("R4 group dlog", 32'(dlog), 1);
      consume();
      lower(5);
   endtask

   task automatic t_anyone();
      logic [7:0] exp_seq [4] = '{8'h02, 8'h10, 8'h40, 8'h02};
      set_ent(6, 8'h90, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h2A);
      for (int i = 0; i < 4; i++) begin
         raise(6);
         chk("R7 rotation", 32'(targets), 32'(exp_seq[i]));
         consume();
         lower(6);
      end
   endtask

   task automatic t_empty_group();
      set_ent(6, 8'h90, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80);
      raise(6);
      chk("R11 empty valid", 32'(valid), 1);
      chk("R11 empty targets", 32'(targets), 0);
      consume();
      lower(6);
      set_ent(6, 8'h90, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h2A);
      raise(6);
      chk("R11 counter not advanced", 32'(targets), 32'h10);
      consume();
      lower(6);
   endtask

   task automatic t_direct_anyone();
      set_ent(7, 8'hA0, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2);
      raise(7);
      chk("R8 dropped", 32'(valid), 0);
      chk("R8 err pulse", 32'(err), 1);
      cyc();
      chk("R8 err one cycle", 32'(err), 0);
      chk("R8 still none", 32'(valid), 0);
      lower(7);
   endtask

   task automatic t_same_cycle();
      pins[0] = 1'b1;
      pins[5] = 1'b1;
      cyc();
      chk("R9 lowest first", 32'(vector), 32'h41);
      cyc();
      chk("R10 stalled vector", 32'(vector), 32'h41);
      consume();
      chk("R9 second valid", 32'(valid), 1);
      chk("R9 second vector", 32'(vector), 32'h5A);
      consume();
      chk("R9 queue empty", 32'(valid), 0);
      pins = '0;
      cyc();
   endtask

   initial begin
      // group bytes: cpu0 01, cpu1 02, cpu2 04, cpu3 01, cpu4 08, cpu5 10, cpu6 20, cpu7 00
      log_ids = {8'h00, 8'h20, 8'h10, 8'h08, 8'h01, 8'h04, 8'h02, 8'h01};
      cyc(3);
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_direct_fixed();
      t_held_pin();
      t_blocked();
      t_bcast();
      t_ext();
      t_group();
      t_anyone();
      t_empty_group();
      t_direct_anyone();
      t_same_cycle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule